// File: doc/BRIEF.md
# Branch Trace Capture Unit

This unit keeps a record of the latest break in sequential program flow for a core whose instructions are all 16 bits wide. A break is a taken branch, the wrap of a hardware repeat loop (both arrive on the branch request), or an accepted interrupt. While tracing is switched on, every break overwrites two registers. The source register holds a reference base address, a 3-bit halfword pointer and a pointer-valid flag. The destination register holds the address where execution resumes.

Software recovers the last instruction executed before the break as base minus twice the pointer. There is one exception. If an interrupt is taken after a delayed branch but before the branch target has run, and that target sits at a 4n+2 address, then the base holds the target itself and the pointer carries no meaning. The unit clears the valid flag in that case. A combinational output gives the rebuilt address, or the bare base when the pointer is not valid.

Top module: `brtrace_unit`

## Requirements
- R1: A synchronous reset sets the trace-enable bit, both trace registers, the pointer-valid flag and the rebuilt-address output to zero.
- R2: A cycle with `en_wr` high loads `en_data` into the trace-enable bit at that edge. A break in the same cycle is judged against the enable value held before the edge.
- R3: While the trace-enable bit is 0, the source base, pointer, valid flag and destination keep their values whatever breaks arrive.
- R4: A branch request captures `br_base`, `br_ptr` and `br_dest` at the next edge, sets the valid flag to 1, and writes 0 into bit 0 of both stored addresses.
- R5: An interrupt request without `irq_dslot` captures `irq_base`, `irq_ptr` and `irq_dest`, with bit 0 cleared and the valid flag set to 1.
- R6: An interrupt request with `irq_dslot` high and bit 1 of `irq_base` set stores that base and pointer and clears the valid flag.
- R7: An interrupt request with `irq_dslot` high and bit 1 of `irq_base` clear still sets the valid flag to 1.
- R8: When branch and interrupt requests arrive in the same cycle, the registers take the interrupt's values.
- R9: `last_exec_addr` equals `src_base - 2*src_ptr` while the valid flag is 1, and equals `src_base` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the trace-enable bit |
| en_data | input | 1 | Value to write into the trace-enable bit |
| br_req | input | 1 | Taken branch or repeat-loop wrap |
| br_base | input | 32 | Reference base address for the branch |
| br_ptr | input | 3 | Halfword pointer for the branch |
| br_dest | input | 32 | Branch destination address |
| irq_req | input | 1 | Interrupt accepted |
| irq_base | input | 32 | Reference base address for the interrupt |
| irq_ptr | input | 3 | Halfword pointer for the interrupt |
| irq_dest | input | 32 | Interrupt handler address |
| irq_dslot | input | 1 | Interrupt arrived after a delayed branch, before its target ran |
| trace_en | output | 1 | Current trace-enable bit |
| src_base | output | 32 | Stored source base address |
| src_ptr | output | 3 | Stored halfword pointer |
| src_ptr_ok | output | 1 | Pointer-valid flag |
| dst_addr | output | 32 | Stored destination address |
| last_exec_addr | output | 32 | Rebuilt last executed address |

## Verification
Two pairs of events can fall in the same cycle: a branch request together with an interrupt request, and a write to the enable bit together with a break. The bench drives both pairs directly and also lets them collide at random. It expects the registers to show the interrupt in the first pair. In the second pair it expects capture to follow the enable value held before the edge. A software model tracks the enable bit and the registers, including the 4n+2 delayed-slot rule, and the bench compares every output against that model after each cycle.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned PTR_W_DEF  = 3;

  typedef enum logic [1:0] {
    DK_NONE   = 2'd0,
    DK_BRANCH = 2'd1,
    DK_IRQ    = 2'd2
  } disc_kind_e;
endpackage

// File: rtl/brtrace_arb.sv
module brtrace_arb #(
  parameter int unsigned AW = brtrace_pkg::ADDR_W_DEF,
  parameter int unsigned PW = brtrace_pkg::PTR_W_DEF
) (
  input  logic          en,
  input  logic          br_req,
  input  logic [AW-1:0] br_base,
  input  logic [PW-1:0] br_ptr,
  input  logic [AW-1:0] br_dest,
  input  logic          irq_req,
  input  logic [AW-1:0] irq_base,
  input  logic [PW-1:0] irq_ptr,
  input  logic [AW-1:0] irq_dest,
  input  logic          irq_dslot,
  output logic          cap_fire,
  output brtrace_pkg::disc_kind_e cap_kind,
  output logic [AW-1:0] cap_base,
  output logic [PW-1:0] cap_ptr,
  output logic [AW-1:0] cap_dest,
  output logic          cap_ptr_ok
);
  import brtrace_pkg::*;

  function automatic logic [AW-1:0] hw_align(input logic [AW-1:0] a);
    return {a[AW-1:1], 1'b0};
  endfunction

  // pointer is meaningless only for an interrupt that split a delayed
  // branch from a target sitting on an odd halfword of a word
  function automatic logic ptr_usable(input disc_kind_e k,
                                      input logic dslot,
                                      input logic [AW-1:0] base);
    return !((k == DK_IRQ) && dslot && base[1]);
  endfunction

  always_comb begin
    if (irq_req)     cap_kind = DK_IRQ;
    else if (br_req) cap_kind = DK_BRANCH;
    else             cap_kind = DK_NONE;

    cap_fire = en && (cap_kind != DK_NONE);

    if (cap_kind == DK_IRQ) begin
      cap_base = hw_align(irq_base);
      cap_ptr  = irq_ptr;
      cap_dest = hw_align(irq_dest);
    end else begin
      cap_base = hw_align(br_base);
      cap_ptr  = br_ptr;
      cap_dest = hw_align(br_dest);
    end
    cap_ptr_ok = ptr_usable(cap_kind, irq_dslot, irq_base);
  end
endmodule

// File: rtl/brtrace_regs.sv
module brtrace_regs #(
  parameter int unsigned AW = brtrace_pkg::ADDR_W_DEF,
  parameter int unsigned PW = brtrace_pkg::PTR_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic          en_data,
  input  logic          cap_fire,
  input  logic [AW-1:0] cap_base,
  input  logic [PW-1:0] cap_ptr,
  input  logic [AW-1:0] cap_dest,
  input  logic          cap_ptr_ok,
  output logic          trace_en,
  output logic [AW-1:0] src_base,
  output logic [PW-1:0] src_ptr,
  output logic          src_ptr_ok,
  output logic [AW-1:0] dst_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trace_en   <= 1'b0;
      src_base   <= '0;
      src_ptr    <= '0;
      src_ptr_ok <= 1'b0;
      dst_addr   <= '0;
    end else begin
      if (en_wr) trace_en <= en_data;
      if (cap_fire) begin
        src_base   <= cap_base;
        src_ptr    <= cap_ptr;
        src_ptr_ok <= cap_ptr_ok;
        dst_addr   <= cap_dest;
      end
    end
  end

  assert_en_load_R2: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (trace_en == $past(en_data)));

  assert_hold_off_R3: assert property (@(posedge clk) disable iff (rst)
    !trace_en |=> ($stable(src_base) && $stable(src_ptr) &&
                   $stable(src_ptr_ok) && $stable(dst_addr)));

  assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> (!src_base[0] && !dst_addr[0]));
endmodule

// File: rtl/brtrace_recon.sv
module brtrace_recon #(
  parameter int unsigned AW = brtrace_pkg::ADDR_W_DEF,
  parameter int unsigned PW = brtrace_pkg::PTR_W_DEF
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] ptr,
  input  logic          ptr_ok,
  output logic [AW-1:0] addr
);
  localparam int unsigned OFS_W = PW + 1;

  function automatic logic [AW-1:0] rebuild(input logic [AW-1:0] b,
                                            input logic [PW-1:0] p);
    logic [OFS_W-1:0] ofs;
    ofs = {p, 1'b0};
    return b - AW'(ofs);
  endfunction

  always_comb addr = ptr_ok ? rebuild(base, ptr) : base;
endmodule

// File: rtl/brtrace_unit.sv
module brtrace_unit #(
  parameter int unsigned AW = brtrace_pkg::ADDR_W_DEF,
  parameter int unsigned PW = brtrace_pkg::PTR_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic          en_data,
  input  logic          br_req,
  input  logic [AW-1:0] br_base,
  input  logic [PW-1:0] br_ptr,
  input  logic [AW-1:0] br_dest,
  input  logic          irq_req,
  input  logic [AW-1:0] irq_base,
  input  logic [PW-1:0] irq_ptr,
  input  logic [AW-1:0] irq_dest,
  input  logic          irq_dslot,
  output logic          trace_en,
  output logic [AW-1:0] src_base,
  output logic [PW-1:0] src_ptr,
  output logic          src_ptr_ok,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] last_exec_addr
);
  import brtrace_pkg::*;

  logic          cap_fire;
  disc_kind_e    cap_kind;
  logic [AW-1:0] cap_base;
  logic [PW-1:0] cap_ptr;
  logic [AW-1:0] cap_dest;
  logic          cap_ptr_ok;

  brtrace_arb #(.AW(AW), .PW(PW)) u_arb (
    .en(trace_en), .br_req(br_req), .br_base(br_base), .br_ptr(br_ptr),
    .br_dest(br_dest), .irq_req(irq_req), .irq_base(irq_base),
    .irq_ptr(irq_ptr), .irq_dest(irq_dest), .irq_dslot(irq_dslot),
    .cap_fire(cap_fire), .cap_kind(cap_kind), .cap_base(cap_base),
    .cap_ptr(cap_ptr), .cap_dest(cap_dest), .cap_ptr_ok(cap_ptr_ok)
  );

  brtrace_regs #(.AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_data(en_data),
    .cap_fire(cap_fire), .cap_base(cap_base), .cap_ptr(cap_ptr),
    .cap_dest(cap_dest), .cap_ptr_ok(cap_ptr_ok), .trace_en(trace_en),
    .src_base(src_base), .src_ptr(src_ptr), .src_ptr_ok(src_ptr_ok),
    .dst_addr(dst_addr)
  );

  brtrace_recon #(.AW(AW), .PW(PW)) u_recon (
    .base(src_base), .ptr(src_ptr), .ptr_ok(src_ptr_ok),
    .addr(last_exec_addr)
  );

  assert_irq_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (trace_en && br_req && irq_req) |=>
      (dst_addr[AW-1:1] == $past(irq_dest[AW-1:1])));

  assert_branch_ok_R4: assert property (@(posedge clk) disable iff (rst)
    (trace_en && br_req && !irq_req) |=> src_ptr_ok);

  assert_odd_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (trace_en && irq_req && irq_dslot && irq_base[1]) |=>
      (!src_ptr_ok && src_base[1]));

  assert_plain_irq_R5: assert property (@(posedge clk) disable iff (rst)
    (trace_en && irq_req && !irq_dslot) |=> src_ptr_ok);

  assert_recon_R9: assert property (@(posedge clk) disable iff (rst)
    src_ptr_ok |-> ((last_exec_addr + AW'({src_ptr, 1'b0})) == src_base));

  assert_recon_bare_R9: assert property (@(posedge clk) disable iff (rst)
    !src_ptr_ok |-> (last_exec_addr == src_base));
endmodule

// File: tb/sim_brtrace_unit.sv
`timescale 1ns/1ps
module sim_brtrace_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        en_wr, en_data;
  logic        br_req, irq_req, irq_dslot;
  logic [31:0] br_base, br_dest, irq_base, irq_dest;
  logic [2:0]  br_ptr, irq_ptr;
  logic        trace_en, src_ptr_ok;
  logic [31:0] src_base, dst_addr, last_exec_addr;
  logic [2:0]  src_ptr;

  int n_run = 0;
  int n_bad = 0;

  logic        m_en, m_ok;
  logic [31:0] m_base, m_dst;
  logic [2:0]  m_ptr;

  always #2.5 clk = ~clk;

  brtrace_unit u0 (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_data(en_data),
    .br_req(br_req), .br_base(br_base), .br_ptr(br_ptr), .br_dest(br_dest),
    .irq_req(irq_req), .irq_base(irq_base), .irq_ptr(irq_ptr),
    .irq_dest(irq_dest), .irq_dslot(irq_dslot), .trace_en(trace_en),
    .src_base(src_base), .src_ptr(src_ptr), .src_ptr_ok(src_ptr_ok),
    .dst_addr(dst_addr), .last_exec_addr(last_exec_addr)
  );

  function automatic logic [31:0] even(input logic [31:0] a);
    return a & 32'hFFFF_FFFE;
  endfunction

  function automatic logic [31:0] exp_last(input logic [31:0] b,
                                           input logic [2:0] p,
                                           input logic ok);
    if (!ok) return b;
    return b - 32'(p) * 32'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " enable"}, 32'(trace_en), 32'(m_en));
    chk({tag, " base"},   src_base, m_base);
    chk({tag, " ptr"},    32'(src_ptr), 32'(m_ptr));
    chk({tag, " ok"},     32'(src_ptr_ok), 32'(m_ok));
    chk({tag, " dest"},   dst_addr, m_dst);
    chk({tag, " R9 last"}, last_exec_addr, exp_last(m_base, m_ptr, m_ok));
  endtask

  task automatic idle_inputs();
    en_wr = 0; en_data = 0; br_req = 0; irq_req = 0; irq_dslot = 0;
    br_base = 0; br_dest = 0; br_ptr = 0;
    irq_base = 0; irq_dest = 0; irq_ptr = 0;
  endtask

  // one cycle: inputs are already set at negedge; model then advances
  task automatic step(input string tag);
    logic was_en;
    was_en = m_en;
    @(posedge clk);
    if (en_wr) m_en = en_data;
    if (was_en && (irq_req || br_req)) begin
      if (irq_req) begin
        m_base = even(irq_base); m_ptr = irq_ptr; m_dst = even(irq_dest);
        m_ok = !(irq_dslot && irq_base[1]);
      end else begin
        m_base = even(br_base); m_ptr = br_ptr; m_dst = even(br_dest);
        m_ok = 1'b1;
      end
    end
    #1;
    chk_all(tag);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    m_en = 0; m_ok = 0; m_base = 0; m_ptr = 0; m_dst = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    #0.1;
    chk_all("R1 reset");

    // R3: disabled, branch is ignored
    br_req = 1; br_base = 32'h1111_2223; br_ptr = 3'd4; br_dest = 32'h4444_0001;
    step("R3 off branch");

    // R2: enable write collides with a branch -> no capture this edge
    en_wr = 1; en_data = 1; br_req = 1; br_base = 32'h5000_0010;
    br_ptr = 3'd2; br_dest = 32'h6000_0020;
    step("R2 enable+branch");

    // R4: branch with odd address bits
    br_req = 1; br_base = 32'h1000_0011; br_ptr = 3'd5; br_dest = 32'h2000_0003;
    step("R4 branch");

    // R5: plain interrupt
    irq_req = 1; irq_base = 32'h3000_0106; irq_ptr = 3'd7; irq_dest = 32'h0000_0600;
    step("R5 irq");

    // R6: interrupt after delayed branch, target on 4n+2
    irq_req = 1; irq_dslot = 1; irq_base = 32'h3000_0006; irq_ptr = 3'd3;
    irq_dest = 32'h0000_0600;
    step("R6 irq dslot 4n+2");

    // R7: delayed-slot interrupt but target on 4n
    irq_req = 1; irq_dslot = 1; irq_base = 32'h3000_0008; irq_ptr = 3'd1;
    irq_dest = 32'h0000_0700;
    step("R7 irq dslot 4n");

    // R8: branch and interrupt together
    br_req = 1; br_base = 32'h7000_0000; br_ptr = 3'd6; br_dest = 32'h7100_0000;
    irq_req = 1; irq_base = 32'h8000_0012; irq_ptr = 3'd2; irq_dest = 32'h8100_0004;
    step("R8 collide");

    // R3: disable, then interrupt is ignored
    en_wr = 1; en_data = 0;
    step("R2 disable");
    irq_req = 1; irq_dslot = 1; irq_base = 32'h9000_0002; irq_dest = 32'h9100_0000;
    step("R3 off irq");
    en_wr = 1; en_data = 1;
    step("R2 re-enable");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      en_wr   = (r[3:0] == 4'd0);
      en_data = r[4];
      br_req  = r[5];
      irq_req = r[6] & r[7];
      irq_dslot = r[8];
      br_base  = $urandom; br_dest  = $urandom; br_ptr  = 3'($urandom);
      irq_base = $urandom; irq_dest = $urandom; irq_ptr = 3'($urandom);
      if (r[9]) irq_base[1] = 1'b1;
      if (r[10]) br_dest[1:0] = 2'b10;
      if (irq_req && br_req)       step("R8 rand");
      else if (irq_req && irq_dslot) step("R6 R7 rand");
      else if (irq_req)            step("R5 rand");
      else if (br_req && m_en)     step("R4 rand");
      else                         step("R3 rand");
    end

    rst = 1;
    @(negedge clk);
    rst = 0;
    m_en = 0; m_ok = 0; m_base = 0; m_ptr = 0; m_dst = 0;
    #0.1;
    chk_all("R1 re-reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule